// File: doc/BRIEF.md
# Atomic Bit Set/Clear Register Window

This block is a bank of 32-bit control registers shared by several bus masters. Each master has its own request port. Registers in the low address window can be reached three ways: through their plain address, through a set alias, and through a clear alias. A write through an alias changes exactly one bit, and the write data carries the bit number rather than a mask. Two masters can therefore flip different bits of one register without a read-modify-write race. A multi-bit update is done as a series of such single-bit writes, one for each bit that changes.

A second window holds registers that can only be reached by plain reads and writes. Every port is ready on every cycle. A write takes effect on the clock edge that accepts it. A read, or an error indication, comes back on the cycle after the request.

Top module: `atomic_bit_regs`

## Requirements
- R1: After reset every register reads zero, and `rsp_valid` and `rsp_err` are low until a request is accepted.
- R2: A write to an address whose bits [15:14] are `11` sets one bit to 1. The bit is chosen by the data value (0 to 31). The register is the low-window register selected by address bits [13:2]. No other bit changes.
- R3: A write to an address whose bits [15:14] are `10` clears one bit to 0. The bit and the low-window register are chosen as in R2. No other bit changes.
- R4: Plain access works on two windows. The low window holds register i at byte address 4*i, for i < NUM_LO. The high window holds register j at 0x4000 + 4*j, for j < NUM_HI. A plain write stores the full 32-bit word. A read returns data with `rsp_valid` on the next cycle. Address bits [1:0] are ignored.
- R5: Alias addresses always decode to the low window. Writing to (0x4000+4*j) | 0xC000 therefore changes low register j, and high register j keeps its value.
- R6: An alias write whose data is 32 or more leaves the register unchanged and raises `rsp_err` for one cycle on that port.
- R7: A read through a set or clear alias address returns the value of the base register and changes nothing.
- R8: Alias writes from different ports to the same register in the same cycle are all applied. If a set and a clear hit the same bit, the bit ends at 0.
- R9: In one cycle, plain writes to a register are resolved before alias writes, and the alias bit changes are applied on top of the plain value. If several plain writes hit one register, the lowest-numbered port wins.
- R10: An access to an unmapped word is handled as follows. In the low or alias window that is word >= NUM_LO; in the high window it is word >= NUM_HI. A write is ignored. A read returns zero. Both raise `rsp_err` on the next cycle.
- R11: A read issued in the same cycle as a write to the same register returns the value from before the write.
- R12: `req_ready` is high on every port in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Request valid, one bit per port |
| req_ready | output | NUM_PORTS | Request accepted (always high) |
| req_addr | input | NUM_PORTS x AW | Byte address per port |
| req_we | input | NUM_PORTS | 1 = write, 0 = read |
| req_wdata | input | NUM_PORTS x DW | Write data, or bit index for alias writes |
| rsp_valid | output | NUM_PORTS | Read data valid, one cycle after a read |
| rsp_rdata | output | NUM_PORTS x DW | Read data |
| rsp_err | output | NUM_PORTS | Bad bit index or unmapped address, one cycle after the request |

## Verification
The bench aims at the cases where ports collide.

- **Set and clear on the same bit.** Both ports hit the same bit in one cycle, with the ports in both orders. A design that let the last port win, instead of clear, would leave the bit at 1 in one of the two orders.
- **Plain write plus alias.** A plain write and an alias write land on one register together. A design that dropped the alias would lose that single bit.
- **Two plain writes.** A design that picked the wrong winner would show the other port's word.
- **Bit index of 32 or more.** A design that masked the index down to five bits would modify bit 0 of the register.
- **High-window alias.** An alias address formed from a high-window offset is used. A decoder that did not fold aliases onto the low window would corrupt the high register.
- **Read and write together.** A read is issued alongside a write to the same register. A design that forwarded the write would return the new value instead of the old one.

// File: rtl/atomic_bit_regs.sv
module atomic_bit_regs #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_LO    = 8,
  parameter int NUM_HI    = 4,
  parameter int AW        = 16,
  parameter int DW        = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PORTS-1:0]           req_valid,
  output logic [NUM_PORTS-1:0]           req_ready,
  input  logic [NUM_PORTS-1:0][AW-1:0]   req_addr,
  input  logic [NUM_PORTS-1:0]           req_we,
  input  logic [NUM_PORTS-1:0][DW-1:0]   req_wdata,
  output logic [NUM_PORTS-1:0]           rsp_valid,
  output logic [NUM_PORTS-1:0][DW-1:0]   rsp_rdata,
  output logic [NUM_PORTS-1:0]           rsp_err
);
  localparam int NREG = NUM_LO + NUM_HI;
  localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int BW   = $clog2(DW);
  localparam int WW   = AW - 4;

  logic [NREG-1:0][DW-1:0]      regs, regs_nxt;
  logic [DW-1:0]                setm, clrm;
  logic [NUM_PORTS-1:0][1:0]    win;
  logic [NUM_PORTS-1:0][WW-1:0] word;
  logic [NUM_PORTS-1:0][IW-1:0] idx;
  logic [NUM_PORTS-1:0][DW-1:0] onehot;
  logic [NUM_PORTS-1:0]         hi, mapped, idx_ok, wr, is_set, is_clr, is_plain;

  assign req_ready = '1;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    assign win[p]      = req_addr[p][AW-1:AW-2];
    assign word[p]     = req_addr[p][AW-3:2];
    assign hi[p]       = (win[p] == 2'b01);
    assign mapped[p]   = hi[p] ? (32'(word[p]) < NUM_HI) : (32'(word[p]) < NUM_LO);
    assign idx[p]      = hi[p] ? IW'(NUM_LO + 32'(word[p])) : IW'(word[p]);
    assign idx_ok[p]   = (req_wdata[p][DW-1:BW] == '0);
    assign onehot[p]   = idx_ok[p] ? (DW'(1) << req_wdata[p][BW-1:0]) : '0;
    assign wr[p]       = req_valid[p] & req_we[p] & mapped[p];
    assign is_set[p]   = wr[p] & (win[p] == 2'b11);
    assign is_clr[p]   = wr[p] & (win[p] == 2'b10);
    assign is_plain[p] = wr[p] & ~win[p][1];
  end

  always_comb begin
    setm = '0;
    clrm = '0;
    for (int r = 0; r < NREG; r++) begin
      regs_nxt[r] = regs[r];
      setm = '0;
      clrm = '0;
      for (int p = NUM_PORTS - 1; p >= 0; p--)
        if (is_plain[p] && idx[p] == IW'(r)) regs_nxt[r] = req_wdata[p];
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (is_set[p] && idx[p] == IW'(r)) setm = setm | onehot[p];
        if (is_clr[p] && idx[p] == IW'(r)) clrm = clrm | onehot[p];
      end
      regs_nxt[r] = (regs_nxt[r] | setm) & ~clrm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs      <= '0;
      rsp_valid <= '0;
      rsp_err   <= '0;
      rsp_rdata <= '0;
    end else begin
      regs <= regs_nxt;
      for (int p = 0; p < NUM_PORTS; p++) begin
        rsp_valid[p] <= req_valid[p] & ~req_we[p];
        rsp_err[p]   <= req_valid[p] & (~mapped[p] | (req_we[p] & win[p][1] & ~idx_ok[p]));
        rsp_rdata[p] <= (req_valid[p] && !req_we[p] && mapped[p]) ? regs[idx[p]] : '0;
      end
    end
  end
endmodule

// File: rtl/abr_check.sv
module abr_check #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_LO    = 8,
  parameter int NUM_HI    = 4,
  parameter int AW        = 16,
  parameter int DW        = 32
) (
  input logic                                      clk,
  input logic                                      rst_n,
  input logic [NUM_PORTS-1:0]                      req_valid,
  input logic [NUM_PORTS-1:0]                      req_ready,
  input logic [NUM_PORTS-1:0][AW-1:0]              req_addr,
  input logic [NUM_PORTS-1:0]                      req_we,
  input logic [NUM_PORTS-1:0][DW-1:0]              req_wdata,
  input logic [NUM_PORTS-1:0]                      rsp_valid,
  input logic [NUM_PORTS-1:0]                      rsp_err,
  input logic [NUM_LO+NUM_HI-1:0][DW-1:0]          regs
);
  localparam int NREG = NUM_LO + NUM_HI;
  localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int BW   = $clog2(DW);

  logic [AW-5:0]  c_word;
  logic           c_low_ok, c_small, c_alias_wr;
  logic [IW-1:0]  p_idx;
  logic [BW-1:0]  p_bit;

  assign c_word     = req_addr[0][AW-3:2];
  assign c_low_ok   = 32'(c_word) < NUM_LO;
  assign c_small    = req_wdata[0] < DW;
  assign c_alias_wr = req_valid[0] & req_we[0] & req_addr[0][AW-1] & c_low_ok & c_small;

  always_ff @(posedge clk) begin
    p_idx <= IW'(c_word);
    p_bit <= req_wdata[0][BW-1:0];
  end

  assert_always_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == {NUM_PORTS{1'b1}});

  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_alias_wr && req_addr[0][AW-2] && (req_valid & req_we) == NUM_PORTS'(1))
    |=> regs[p_idx][p_bit]);

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_alias_wr && !req_addr[0][AW-2]) |=> !regs[p_idx][p_bit]);

  assert_no_write_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(req_valid & req_we)) |=> $stable(regs));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assert_rsp_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[p] |-> $past(req_valid[p] && !req_we[p]));
    assert_bad_index_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && req_we[p] && req_addr[p][AW-1] && req_wdata[p] >= DW) |=> rsp_err[p]);
  end
endmodule

bind atomic_bit_regs abr_check #(
  .NUM_PORTS(NUM_PORTS), .NUM_LO(NUM_LO), .NUM_HI(NUM_HI), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .regs(regs)
);

// File: tb/sim_atomic_bit_regs.sv
module sim_atomic_bit_regs;
  localparam int NP = 2, NLO = 8, NHI = 4, AW = 16, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0]          req_valid = '0, req_ready, req_we = '0;
  logic [NP-1:0][AW-1:0]  req_addr = '0;
  logic [NP-1:0][DW-1:0]  req_wdata = '0;
  logic [NP-1:0]          rsp_valid, rsp_err;
  logic [NP-1:0][DW-1:0]  rsp_rdata;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  atomic_bit_regs #(.NUM_PORTS(NP), .NUM_LO(NLO), .NUM_HI(NHI), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(int p, logic [15:0] a, logic we, logic [31:0] d);
    req_valid[p] = 1'b1; req_addr[p] = a; req_we[p] = we; req_wdata[p] = d;
  endtask

  task automatic step();
    @(negedge clk);
    req_valid = '0; req_we = '0;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    drive(0, a, 1'b1, d); step();
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d, output logic e);
    drive(0, a, 1'b0, 0); step();
    d = rsp_rdata[0]; e = rsp_err[0];
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    chk("R1 rsp_valid idle", 32'(rsp_valid), 0);
    chk("R1 rsp_err idle", 32'(rsp_err), 0);
    for (int i = 0; i < NLO; i++) begin rd(16'(4*i), d, e); chk("R1 low reg", d, 0); end
    for (int j = 0; j < NHI; j++) begin rd(16'h4000 + 16'(4*j), d, e); chk("R1 high reg", d, 0); end
    chk("R12 ready", 32'(req_ready), 3);
  endtask

  task automatic t_plain();
    logic [31:0] d; logic e;
    wr(16'h0004, 32'hDEADBEEF);
    wr(16'h400C, 32'h0BADF00D);
    rd(16'h0004, d, e);
    chk("R4 low rdata", d, 32'hDEADBEEF); chk("R4 rsp_valid", 32'(rsp_valid[0]), 1);
    rd(16'h400C, d, e); chk("R4 high rdata", d, 32'h0BADF00D);
    rd(16'h0007, d, e); chk("R4 low bits ignored", d, 32'hDEADBEEF);
  endtask

  task automatic t_set_clear();
    logic [31:0] d; logic e;
    wr(16'h0008, 0);
    wr(16'hC008, 0); wr(16'hC008, 31); wr(16'hC008, 5);
    rd(16'h0008, d, e); chk("R2 set bits", d, 32'h80000021);
    wr(16'h8008, 5);
    rd(16'h0008, d, e); chk("R3 clear bit", d, 32'h80000001);
    chk("R2 no err", 32'(e), 0);
  endtask

  task automatic t_multibit();
    logic [31:0] d, m, v, old; logic e;
    old = 32'hFFFF0000; m = 32'h00FFF0F0; v = 32'h00A0A0A0;
    wr(16'h000C, old);
    for (int b = 0; b < 32; b++)
      if (m[b]) wr(v[b] ? 16'hC00C : 16'h800C, 32'(b));
    rd(16'h000C, d, e); chk("R2 R3 mask update", d, (old & ~m) | (v & m));
  endtask

  task automatic t_bad_index();
    logic [31:0] d; logic e;
    wr(16'h0008, 32'h00000010);
    wr(16'hC008, 32);
    chk("R6 err on 32", 32'(rsp_err[0]), 1);
    wr(16'h8008, 32'hFFFFFFE4);
    chk("R6 err on big", 32'(rsp_err[0]), 1);
    rd(16'h0008, d, e); chk("R6 unchanged", d, 32'h00000010);
    chk("R6 err clears", 32'(e), 0);
  endtask

  task automatic t_alias_read();
    logic [31:0] d; logic e;
    rd(16'hC008, d, e); chk("R7 set alias read", d, 32'h00000010);
    rd(16'h8008, d, e); chk("R7 clear alias read", d, 32'h00000010);
    rd(16'h0008, d, e); chk("R7 no side effect", d, 32'h00000010);
  endtask

  task automatic t_high_alias();
    logic [31:0] d; logic e;
    wr(16'h4004, 32'h12345678);
    wr(16'h0004, 0);
    wr(16'h4004 | 16'hC000, 3);
    rd(16'h0004, d, e); chk("R5 low reg hit", d, 32'h8);
    rd(16'h4004, d, e); chk("R5 high reg kept", d, 32'h12345678);
  endtask

  task automatic t_dual();
    logic [31:0] d; logic e;
    wr(16'h0010, 0);
    drive(0, 16'hC010, 1, 1); drive(1, 16'hC010, 1, 2); step();
    rd(16'h0010, d, e); chk("R8 both sets", d, 32'h6);
    drive(0, 16'hC010, 1, 7); drive(1, 16'h8010, 1, 7); step();
    rd(16'h0010, d, e); chk("R8 clear wins p1", d, 32'h6);
    wr(16'h0010, 32'h80);
    drive(0, 16'h8010, 1, 7); drive(1, 16'hC010, 1, 7); step();
    rd(16'h0010, d, e); chk("R8 clear wins p0", d, 0);
  endtask

  task automatic t_plain_vs_alias();
    logic [31:0] d; logic e;
    wr(16'h0014, 32'hFFFFFFFF);
    drive(0, 16'h0014, 1, 0); drive(1, 16'hC014, 1, 4); step();
    rd(16'h0014, d, e); chk("R9 plain then set", d, 32'h10);
    drive(0, 16'h0014, 1, 32'hAAAA); drive(1, 16'h0014, 1, 32'h5555); step();
    rd(16'h0014, d, e); chk("R9 low port wins", d, 32'hAAAA);
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic e;
    wr(16'h0020, 32'h1234);
    chk("R10 low write err", 32'(rsp_err[0]), 1);
    rd(16'h0020, d, e); chk("R10 low read zero", d, 0); chk("R10 low read err", 32'(e), 1);
    rd(16'h4010, d, e); chk("R10 high read zero", d, 0); chk("R10 high read err", 32'(e), 1);
    rd(16'h0000, d, e); chk("R10 reg0 untouched", d, 0);
  endtask

  task automatic t_read_during_write();
    logic [31:0] d; logic e;
    drive(0, 16'h0018, 1, 32'h77); drive(1, 16'h0018, 0, 0); step();
    chk("R11 old value", rsp_rdata[1], 0);
    chk("R11 p1 valid", 32'(rsp_valid[1]), 1);
    rd(16'h0018, d, e); chk("R11 new value", d, 32'h77);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_set_clear();
    t_multibit();
    t_bad_index();
    t_alias_read();
    t_high_alias();
    t_dual();
    t_plain_vs_alias();
    t_unmapped();
    t_read_during_write();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end
endmodule